// File: doc/BRIEF.md
# Pin-to-Resource Routing Matrix

This block sits between the general-purpose digital pins and a handful of internal consumers. Each pin carries a 3-bit selection code. The code either leaves the pin unrouted or connects it to one of four targets: one of two counter clock enables, or one of two interrupt request lines (high and low priority). An interrupt selection also names the edge it responds to, rising or falling. Every pad level passes through a two-flop synchronizer before edge detection. Because the level is taken from the pad itself, a pin the device drives as an output is watched just like an input, which lets the device count pulses that it emits.

All pins that target the same resource are combined with a logical OR. Each resource output is a registered pulse one clock wide. The counters and the interrupt controller stay in the system clock domain.

On the output side there is an override mux. Two pins can be handed to a compute engine's strobe and fault pulse outputs, but only while those pins are set as outputs. Two further pins can be given to a serial EEPROM clock and data pair. The synchronized level of every pad is returned on a read-back bus.

Top module: `pin_resource_router`

## Requirements
- R1: Selection codes 0 and 1 route the pin to nothing. Toggling such a pin never raises any resource output.
- R2: Code 2 gives one `cnt0_en_o` pulse for each rising pad edge, and code 3 does the same on `cnt1_en_o`. Falling edges on these codes produce nothing.
- R3: Code 4 pulses `irq_hi_o` on a rising pad edge, and code 5 pulses `irq_lo_o` on a rising pad edge.
- R4: Code 6 pulses `irq_hi_o` on a falling pad edge, and code 7 pulses `irq_lo_o` on a falling pad edge. The opposite edge produces nothing.
- R5: Pins that hit the same resource in the same cycle are OR-merged into a single pulse.
- R6: A pad change set up before clock edge k gives a resource pulse that is high in the cycle after edge k+2. The pulse lasts exactly one cycle, and outputs are otherwise low.
- R7: A pin whose direction bit is 1 (output) is still routed from its driven pad level, so its own output data produces edges.
- R8: `rdbk_o[p]` equals the pad level sampled two clock edges earlier.
- R9: Pin 6 carries `strobe_i` and pin 7 carries `fault_i` only when the matching enable is 1 and the pin's direction bit is 1. Otherwise the pin drives its output data bit.
- R10: With `ee_en_i` = 1, pin 4 is an output carrying `ee_clk_i`. Pin 5 drives `ee_dat_i` with its output enable taken from `ee_dat_oe_i`.
- R11: While `rst_ni` is low, all resource outputs and `rdbk_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pad_i | input | NUM_PINS | Pad levels as seen at the pins |
| dir_i | input | NUM_PINS | Direction per pin, 1 = output |
| dout_i | input | NUM_PINS | Output data per pin |
| sel_i | input | 3*NUM_PINS | Selection code per pin, pin p at bits [3p+2:3p] |
| strobe_en_i | input | 1 | Hand the strobe pin to the compute engine |
| strobe_i | input | 1 | Strobe pulse from the compute engine |
| fault_en_i | input | 1 | Hand the fault pin to the compute engine |
| fault_i | input | 1 | Fault pulse from the compute engine |
| ee_en_i | input | 1 | Hand the two EEPROM pins to the serial interface |
| ee_clk_i | input | 1 | EEPROM serial clock |
| ee_dat_i | input | 1 | EEPROM data to drive |
| ee_dat_oe_i | input | 1 | EEPROM data output enable |
| pad_o | output | NUM_PINS | Data to the pad drivers |
| pad_oe_o | output | NUM_PINS | Output enable to the pad drivers |
| rdbk_o | output | NUM_PINS | Synchronized pad levels |
| cnt0_en_o | output | 1 | Counter 0 clock enable pulse |
| cnt1_en_o | output | 1 | Counter 1 clock enable pulse |
| irq_hi_o | output | 1 | High-priority interrupt pulse |
| irq_lo_o | output | 1 | Low-priority interrupt pulse |

## Verification
The bench uses the defaults: eight pins, the EEPROM pair on pins 4 and 5, and strobe and fault on pins 6 and 7. With these values all eight selection codes can be reached, along with both override pairs and the interplay between them. A pin handed to an override can then be routed back into a counter or an interrupt. That covers the self-driven pulse-counting path for strobe pulses, for EEPROM clocks and for plain output data. It also means two pins can fire into one resource in the same cycle.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    RT_NONE    = 3'd0,
    RT_RSVD    = 3'd1,
    RT_CNT0    = 3'd2,
    RT_CNT1    = 3'd3,
    RT_HI_RISE = 3'd4,
    RT_LO_RISE = 3'd5,
    RT_HI_FALL = 3'd6,
    RT_LO_FALL = 3'd7
  } route_sel_e;

  typedef struct packed {
    logic cnt0;
    logic cnt1;
    logic irq_hi;
    logic irq_lo;
  } res_vec_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] lvl_o,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o
);
  logic [NUM_PINS-1:0] meta_q, sync_q, dly_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[p] <= 1'b0;
        sync_q[p] <= 1'b0;
        dly_q[p]  <= 1'b0;
      end else begin
        meta_q[p] <= pad_i[p];
        sync_q[p] <= meta_q[p];
        dly_q[p]  <= sync_q[p];
      end
    end
    assign rise_o[p] = sync_q[p] & ~dly_q[p];
    assign fall_o[p] = ~sync_q[p] & dly_q[p];
  end

  assign lvl_o = sync_q;
endmodule

// File: rtl/route_decode.sv
module route_decode
  import router_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int SW = NUM_PINS * SEL_W
) (
  input  logic [SW-1:0]       sel_i,
  input  logic [NUM_PINS-1:0] rise_i,
  input  logic [NUM_PINS-1:0] fall_i,
  output res_vec_t            res_o
);
  res_vec_t hit [NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_dec
    route_sel_e code;
    assign code = route_sel_e'(sel_i[p*SEL_W +: SEL_W]);
    always_comb begin
      hit[p] = '0;
      unique case (code)
        RT_CNT0:    hit[p].cnt0   = rise_i[p];
        RT_CNT1:    hit[p].cnt1   = rise_i[p];
        RT_HI_RISE: hit[p].irq_hi = rise_i[p];
        RT_LO_RISE: hit[p].irq_lo = rise_i[p];
        RT_HI_FALL: hit[p].irq_hi = fall_i[p];
        RT_LO_FALL: hit[p].irq_lo = fall_i[p];
        default:    hit[p]        = '0; // none and reserved
      endcase
    end
  end

  always_comb begin
    res_o = '0;
    for (int p = 0; p < NUM_PINS; p++) res_o = res_o | hit[p];
  end
endmodule

// File: rtl/pad_override_mux.sv
module pad_override_mux #(
  parameter int NUM_PINS   = 8,
  parameter int EE_CLK_PIN = 4,
  parameter int EE_DAT_PIN = 5,
  parameter int STROBE_PIN = 6,
  parameter int FAULT_PIN  = 7
) (
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] dout_i,
  input  logic                strobe_en_i,
  input  logic                strobe_i,
  input  logic                fault_en_i,
  input  logic                fault_i,
  input  logic                ee_en_i,
  input  logic                ee_clk_i,
  input  logic                ee_dat_i,
  input  logic                ee_dat_oe_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  always_comb begin
    pad_o    = dout_i;
    pad_oe_o = dir_i;
    if (ee_en_i) begin
      pad_oe_o[EE_CLK_PIN] = 1'b1;
      pad_o[EE_CLK_PIN]    = ee_clk_i;
      pad_oe_o[EE_DAT_PIN] = ee_dat_oe_i;
      pad_o[EE_DAT_PIN]    = ee_dat_i;
    end
    // engine pulses take the pin only when it is already an output
    if (strobe_en_i && dir_i[STROBE_PIN]) pad_o[STROBE_PIN] = strobe_i;
    if (fault_en_i && dir_i[FAULT_PIN])   pad_o[FAULT_PIN]  = fault_i;
  end
endmodule

// File: rtl/pin_resource_router.sv
module pin_resource_router
  import router_pkg::*;
#(
  parameter int NUM_PINS   = 8,
  parameter int EE_CLK_PIN = 4,
  parameter int EE_DAT_PIN = 5,
  parameter int STROBE_PIN = 6,
  parameter int FAULT_PIN  = 7,
  localparam int SW = NUM_PINS * SEL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pad_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] dout_i,
  input  logic [SW-1:0]       sel_i,
  input  logic                strobe_en_i,
  input  logic                strobe_i,
  input  logic                fault_en_i,
  input  logic                fault_i,
  input  logic                ee_en_i,
  input  logic                ee_clk_i,
  input  logic                ee_dat_i,
  input  logic                ee_dat_oe_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] rdbk_o,
  output logic                cnt0_en_o,
  output logic                cnt1_en_o,
  output logic                irq_hi_o,
  output logic                irq_lo_o
);
  logic [NUM_PINS-1:0] rise, fall;
  res_vec_t            res_d, res_q;

  pin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (pad_i),
    .lvl_o  (rdbk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  route_decode #(.NUM_PINS(NUM_PINS)) u_dec (
    .sel_i  (sel_i),
    .rise_i (rise),
    .fall_i (fall),
    .res_o  (res_d)
  );

  pad_override_mux #(
    .NUM_PINS   (NUM_PINS),
    .EE_CLK_PIN (EE_CLK_PIN),
    .EE_DAT_PIN (EE_DAT_PIN),
    .STROBE_PIN (STROBE_PIN),
    .FAULT_PIN  (FAULT_PIN)
  ) u_mux (
    .dir_i       (dir_i),
    .dout_i      (dout_i),
    .strobe_en_i (strobe_en_i),
    .strobe_i    (strobe_i),
    .fault_en_i  (fault_en_i),
    .fault_i     (fault_i),
    .ee_en_i     (ee_en_i),
    .ee_clk_i    (ee_clk_i),
    .ee_dat_i    (ee_dat_i),
    .ee_dat_oe_i (ee_dat_oe_i),
    .pad_o       (pad_o),
    .pad_oe_o    (pad_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= res_d;
  end

  assign cnt0_en_o = res_q.cnt0;
  assign cnt1_en_o = res_q.cnt1;
  assign irq_hi_o  = res_q.irq_hi;
  assign irq_lo_o  = res_q.irq_lo;
endmodule

// File: rtl/pin_resource_router_chk.sv
module pin_resource_router_chk #(
  parameter int NUM_PINS   = 8,
  parameter int EE_CLK_PIN = 4,
  parameter int STROBE_PIN = 6,
  localparam int SW = NUM_PINS * 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] pad_i,
  input logic [NUM_PINS-1:0] dir_i,
  input logic [NUM_PINS-1:0] dout_i,
  input logic [SW-1:0]       sel_i,
  input logic                strobe_en_i,
  input logic                strobe_i,
  input logic                ee_en_i,
  input logic                ee_clk_i,
  input logic [NUM_PINS-1:0] pad_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] rdbk_o,
  input logic                cnt0_en_o,
  input logic                cnt1_en_o,
  input logic                irq_hi_o,
  input logic                irq_lo_o
);
  logic [1:0]          since_q;
  logic [NUM_PINS-1:0] rb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      rb_q    <= '0;
    end else begin
      if (since_q != 2'd3) since_q <= since_q + 2'd1;
      rb_q <= rdbk_o;
    end
  end

  function automatic logic [NUM_PINS-1:0] code_mask(input logic [SW-1:0] s, input logic [2:0] c);
    logic [NUM_PINS-1:0] m;
    for (int p = 0; p < NUM_PINS; p++) m[p] = (s[p*3 +: 3] == c);
    return m;
  endfunction

  // R6
  cnt0_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt0_en_o |=> !cnt0_en_o);
  // R6
  cnt1_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt1_en_o |=> !cnt1_en_o);
  // R6
  irq_hi_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_hi_o |=> !irq_hi_o);
  // R6
  irq_lo_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_lo_o |=> !irq_lo_o);
  // R2
  cnt0_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnt0_en_o) |-> |($past(rdbk_o) & ~$past(rb_q) & code_mask($past(sel_i), 3'd2)));
  // R8
  rdbk_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 2'd2) |-> (rdbk_o == $past(pad_i, 2)));
  // R9
  strobe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_en_i |-> (pad_o[STROBE_PIN] == dout_i[STROBE_PIN]));
  // R9
  strobe_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_en_i && dir_i[STROBE_PIN]) |-> (pad_o[STROBE_PIN] == strobe_i));
  // R10
  ee_clk_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_en_i |-> (pad_oe_o[EE_CLK_PIN] && pad_o[EE_CLK_PIN] == ee_clk_i));
endmodule

bind pin_resource_router pin_resource_router_chk #(
  .NUM_PINS   (NUM_PINS),
  .EE_CLK_PIN (EE_CLK_PIN),
  .STROBE_PIN (STROBE_PIN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pad_i       (pad_i),
  .dir_i       (dir_i),
  .dout_i      (dout_i),
  .sel_i       (sel_i),
  .strobe_en_i (strobe_en_i),
  .strobe_i    (strobe_i),
  .ee_en_i     (ee_en_i),
  .ee_clk_i    (ee_clk_i),
  .pad_o       (pad_o),
  .pad_oe_o    (pad_oe_o),
  .rdbk_o      (rdbk_o),
  .cnt0_en_o   (cnt0_en_o),
  .cnt1_en_o   (cnt1_en_o),
  .irq_hi_o    (irq_hi_o),
  .irq_lo_o    (irq_lo_o)
);

// File: tb/sim_pin_resource_router.sv
`timescale 1ns/100ps
module sim_pin_resource_router;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   ext_r = '0, dir_r = '0, dout_r = '0;
  logic [3*N-1:0] sel_r = '0;
  logic st_en = 0, st = 0, ft_en = 0, ft = 0, ee_en = 0, ee_clk = 0, ee_dat = 0, ee_oe = 0;
  logic [N-1:0]   pad_i, pad_o, pad_oe, rdbk;
  logic           cnt0, cnt1, ihi, ilo;

  always #2.5 clk = ~clk;

  // pad model: a driven pin shows its own output level
  assign pad_i = (pad_oe & pad_o) | (~pad_oe & ext_r);

  pin_resource_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .pad_i(pad_i), .dir_i(dir_r), .dout_i(dout_r), .sel_i(sel_r),
    .strobe_en_i(st_en), .strobe_i(st), .fault_en_i(ft_en), .fault_i(ft),
    .ee_en_i(ee_en), .ee_clk_i(ee_clk), .ee_dat_i(ee_dat), .ee_dat_oe_i(ee_oe),
    .pad_o(pad_o), .pad_oe_o(pad_oe), .rdbk_o(rdbk),
    .cnt0_en_o(cnt0), .cnt1_en_o(cnt1), .irq_hi_o(ihi), .irq_lo_o(ilo)
  );

  typedef struct { int cyc; logic [3:0] exp; string tag; } item_t;
  item_t        sb[$];
  int           cyc = 0, nvec = 0, nerr = 0;
  logic [N-1:0] lvl_prev = '0;
  bit           done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic model_pad(int p);
    if (ee_en && p == 4) return ee_clk;
    if (ee_en && p == 5) return ee_oe ? ee_dat : ext_r[5];
    if (p == 6 && st_en && dir_r[6]) return st;
    if (p == 7 && ft_en && dir_r[7]) return ft;
    return dir_r[p] ? dout_r[p] : ext_r[p];
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // driver: stimulus already set; predict pulses and push into scoreboard
  task automatic apply(string tag);
    logic [N-1:0] nl;
    logic [3:0]   e;
    logic         r, f;
    e = '0;
    for (int p = 0; p < N; p++) begin
      nl[p] = model_pad(p);
      r = nl[p] & ~lvl_prev[p];
      f = ~nl[p] & lvl_prev[p];
      case (sel_r[p*3 +: 3])
        3'd2: e[3] |= r;
        3'd3: e[2] |= r;
        3'd4: e[1] |= r;
        3'd5: e[0] |= r;
        3'd6: e[1] |= f;
        3'd7: e[0] |= f;
        default: ;
      endcase
    end
    sb.push_back('{cyc + 3, e, tag});
    lvl_prev = nl;
    repeat (2) @(negedge clk);
    check("R8", 32'(rdbk), 32'(nl));
    repeat (2) @(negedge clk);
  endtask

  task automatic set_sel(int p, logic [2:0] c);
    sel_r[p*3 +: 3] = c;
  endtask

  // monitor: compare resource outputs every cycle against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] exp;
      string      tag;
      exp = '0;
      tag = "R6";
      if (sb.size() > 0 && sb[0].cyc == cyc) begin
        exp = sb[0].exp;
        tag = sb[0].tag;
        void'(sb.pop_front());
      end
      check(tag, 32'({cnt0, cnt1, ihi, ilo}), 32'(exp));
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", 32'({cnt0, cnt1, ihi, ilo}), 32'd0);
    check("R11", 32'(rdbk), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: codes 0 and 1 route nowhere
    set_sel(0, 3'd0); ext_r[0] = 1; apply("R1"); ext_r[0] = 0; apply("R1");
    set_sel(0, 3'd1); ext_r[0] = 1; apply("R1"); ext_r[0] = 0; apply("R1");

    // R2: counter clocks on rising edge only
    set_sel(1, 3'd2); ext_r[1] = 1; apply("R2"); ext_r[1] = 0; apply("R2");
    set_sel(2, 3'd3); ext_r[2] = 1; apply("R2"); ext_r[2] = 0; apply("R2");

    // R3: rising-edge interrupts
    set_sel(3, 3'd4); ext_r[3] = 1; apply("R3"); ext_r[3] = 0; apply("R3");
    set_sel(0, 3'd5); ext_r[0] = 1; apply("R3"); ext_r[0] = 0; apply("R3");

    // R4: falling-edge interrupts
    set_sel(3, 3'd6); ext_r[3] = 1; apply("R4"); ext_r[3] = 0; apply("R4");
    set_sel(0, 3'd7); ext_r[0] = 1; apply("R4"); ext_r[0] = 0; apply("R4");

    // R5: two pins into one resource, same cycle
    set_sel(0, 3'd4); set_sel(3, 3'd4);
    ext_r[0] = 1; ext_r[3] = 1; apply("R5");
    set_sel(3, 3'd6);
    ext_r[0] = 0; apply("R5");
    ext_r[0] = 1; ext_r[3] = 0; apply("R5");
    set_sel(1, 3'd2); set_sel(2, 3'd2);
    ext_r[1] = 1; ext_r[2] = 1; apply("R5");
    ext_r[0] = 0; ext_r[1] = 0; ext_r[2] = 0; apply("R5");

    // R6: back-to-back edges on successive cycles stay one pulse each
    set_sel(1, 3'd3);
    ext_r[1] = 1; sb.push_back('{cyc + 3, 4'b0100, "R6"}); lvl_prev[1] = 1;
    @(negedge clk); ext_r[1] = 0; lvl_prev[1] = 0;
    @(negedge clk); ext_r[1] = 1; sb.push_back('{cyc + 3, 4'b0100, "R6"}); lvl_prev[1] = 1;
    repeat (5) @(negedge clk);
    ext_r[1] = 0; apply("R6");

    // R7: output pin routed from its own driven level, external level ignored
    set_sel(2, 3'd2); dir_r[2] = 1;
    ext_r[2] = 1; apply("R7");
    dout_r[2] = 1; apply("R7");
    ext_r[2] = 0; apply("R7");
    dout_r[2] = 0; apply("R7");
    dir_r[2] = 0;

    // R9: strobe and fault overrides gated by direction
    set_sel(6, 3'd3); set_sel(7, 3'd5);
    st_en = 1; st = 1; ext_r[6] = 0; apply("R9");
    check("R9", 32'(pad_o[6]), 32'(dout_r[6]));
    check("R9", 32'(pad_oe[6]), 32'd0);
    dir_r[6] = 1; apply("R9");
    check("R9", 32'(pad_o[6]), 32'd1);
    st = 0; apply("R9"); st = 1; apply("R9"); st = 0; apply("R9");
    dir_r[7] = 1; dout_r[7] = 0; ft = 1; apply("R9");
    check("R9", 32'(pad_o[7]), 32'd0);
    ft_en = 1; apply("R9");
    check("R9", 32'(pad_o[7]), 32'd1);
    ft = 0; apply("R9");
    st_en = 0; ft_en = 0; dir_r[6] = 0; dir_r[7] = 0; apply("R9");

    // R10: EEPROM takeover of pins 4 and 5
    set_sel(4, 3'd2); set_sel(5, 3'd7);
    ext_r[5] = 1; apply("R10");
    ee_en = 1; ee_clk = 1; apply("R10");
    check("R10", 32'(pad_oe[4]), 32'd1);
    check("R10", 32'(pad_o[4]), 32'd1);
    check("R10", 32'(pad_oe[5]), 32'd0);
    ee_oe = 1; ee_dat = 0; apply("R10");
    check("R10", 32'(pad_oe[5]), 32'd1);
    check("R10", 32'(pad_o[5]), 32'd0);
    ee_clk = 0; ee_dat = 1; apply("R10");
    ee_en = 0; ee_oe = 0; apply("R10");
    check("R10", 32'(pad_oe[4]), 32'd0);

    repeat (4) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule